// File: doc/BRIEF.md
# Complement-Checked Configuration Byte Loader

At every system reset this block copies eight configuration bytes out of a small non-volatile information area into live registers. The area is four 32-bit words. Each 16-bit half of a word stores a value byte together with its bitwise complement. The loader reads one word per clock and tests every value against its complement. A byte that passes is loaded as stored. A byte that fails is presented as 0xFF and raises a sticky configuration-error flag.

The loaded results are presented as follows:

- a 32-bit write-protection mask
- a read-protection level byte, plus a derived read-protection flag
- a user configuration byte
- two user data bytes

The block only reads the information area. Programming or erasing that area is handled elsewhere. A testbench preloads the area directly. New stored values take effect only after the next reset reloads them.

Top module: `optld_top`

## Requirements
- R1: While `rst_n` is low, `load_done` and `cfg_err` are 0, and every byte output (`prot_mask`, `rdp_level`, `user_cfg`, `udata0`, `udata1`) is all ones, which makes `rd_lock` 1.
- R2: Words are checked one per rising clock edge, in order 0 to 3, starting at the first edge after `rst_n` rises. `load_done` becomes 1 after the fourth such edge. After the first edge only the word-0 fields have their loaded values.
- R3: Word 0 carries the read-protection level in bits [7:0] with its complement in [15:8]. It carries the user configuration byte in [23:16] with its complement in [31:24].
- R4: Word 1 carries user data byte 0 in [7:0] with its complement in [15:8]. It carries user data byte 1 in [23:16] with its complement in [31:24].
- R5: Word 2 carries mask bytes 0 and 1, and word 3 carries mask bytes 2 and 3. Each word has the low-half/high-half layout of R3. Mask byte n drives `prot_mask[8n+7:8n]`.
- R6: A value whose stored complement differs from its bitwise inverse in any bit is presented as 0xFF and sets `cfg_err`. All other bytes of the same load are unaffected.
- R7: `cfg_err` stays set until the next reset. A reload with all pairs valid leaves it 0.
- R8: `rd_lock` is 1 whenever the loaded level byte differs from the unlock code 0xA5. This includes a level forced to 0xFF by a failed pair.
- R9: After `load_done`, a change to the stored words has no effect on any output until a reset reloads them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low system reset; its release starts a load |
| prot_mask | output | 32 | Write-protection mask assembled from four checked bytes |
| rdp_level | output | 8 | Loaded read-protection level byte |
| rd_lock | output | 1 | Read protection active (level differs from unlock code) |
| user_cfg | output | 8 | Loaded user configuration byte |
| udata0 | output | 8 | Loaded user data byte 0 |
| udata1 | output | 8 | Loaded user data byte 1 |
| cfg_err | output | 1 | At least one value/complement pair failed in this load |
| load_done | output | 1 | All four words have been checked |

## Verification
The bench corrupts each of the eight complements in each of its eight bit positions. For every such load it checks that exactly one byte goes to 0xFF and the error flag rises. A design that checked only some bits, or mixed up the slot-to-field mapping, would show the wrong byte replaced or a corrupted value passing through. All 256 level codes are swept with valid complements, together with a forced 0xFF on an otherwise unlocking code. This catches an inverted or mis-compared lock flag. The timing checks and the change-after-load checks catch loaders that run too long or too short, or that keep sampling the area after `load_done`.

// File: rtl/optld_pkg.sv
package optld_pkg;
   localparam int unsigned BYTE_W    = 8;
   localparam int unsigned WORD_W    = 32;
   localparam int unsigned NWORDS    = 4;
   localparam logic [7:0]  UNLOCK_CD = 8'hA5;
   localparam logic [7:0]  FILL_BYTE = 8'hFF;
endpackage

// File: rtl/optld_store.sv
module optld_store #(
   parameter int unsigned WW = 32,
   parameter int unsigned NW = 4,
   parameter logic [NW*WW-1:0] INIT = '1,
   localparam int unsigned AW = (NW > 1) ? $clog2(NW) : 1
) (
   input  logic [AW-1:0] rd_idx,
   output logic [WW-1:0] rd_word
);
   logic [WW-1:0] mem [NW];

   initial begin
      for (int i = 0; i < NW; i++) mem[i] = INIT[i*WW +: WW];
   end

   assign rd_word = mem[rd_idx];
endmodule

// File: rtl/optld_pair_chk.sv
module optld_pair_chk #(
   parameter int unsigned BW = 8
) (
   input  logic [2*BW-1:0] half_in,
   output logic [BW-1:0]   byte_out,
   output logic            pair_ok
);
   logic [BW-1:0] val, cmp;
   assign val      = half_in[BW-1:0];
   assign cmp      = half_in[2*BW-1:BW];
   assign pair_ok  = (cmp == ~val);
   assign byte_out = pair_ok ? val : {BW{1'b1}};
endmodule

// File: rtl/optld_seq.sv
module optld_seq #(
   parameter int unsigned NW = 4,
   localparam int unsigned AW = (NW > 1) ? $clog2(NW) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   output logic [AW-1:0] idx,
   output logic          loading,
   output logic          done
);
   logic last;
   assign last    = (idx == AW'(NW-1));
   assign loading = !done;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx  <= '0;
         done <= 1'b0;
      end else if (!done) begin
         idx <= last ? '0 : idx + 1'b1;
         if (last) done <= 1'b1;
      end
   end

   // R2
   done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> done);
   // R2
   done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> ($past(idx) == AW'(NW-1)));
endmodule

// File: rtl/optld_top.sv
module optld_top #(
   parameter int unsigned BW = optld_pkg::BYTE_W,
   parameter int unsigned WW = optld_pkg::WORD_W,
   parameter int unsigned NW = optld_pkg::NWORDS,
   parameter logic [BW-1:0] UNLOCK = optld_pkg::UNLOCK_CD,
   parameter logic [NW*WW-1:0] INIT = '1
) (
   input  logic        clk,
   input  logic        rst_n,
   output logic [31:0] prot_mask,
   output logic [7:0]  rdp_level,
   output logic        rd_lock,
   output logic [7:0]  user_cfg,
   output logic [7:0]  udata0,
   output logic [7:0]  udata1,
   output logic        cfg_err,
   output logic        load_done
);
   localparam int unsigned HPW = WW / (2*BW);
   localparam int unsigned NSLOT = NW * HPW;
   localparam int unsigned AW = (NW > 1) ? $clog2(NW) : 1;

   generate
      if (BW != 8)          begin : g_bw_bad   $error("byte width must be 8"); end
      if (WW != 4*BW)       begin : g_ww_bad   $error("word must hold two pairs"); end
      if (NW != 4)          begin : g_nw_bad   $error("field map needs four words"); end
   endgenerate

   logic [AW-1:0] idx;
   logic          loading;
   logic [WW-1:0] word;
   logic [BW-1:0] chk_byte [HPW];
   logic [HPW-1:0] chk_ok;
   logic [BW-1:0] fld_q [NSLOT];

   optld_seq #(.NW(NW)) u_seq (
      .clk(clk), .rst_n(rst_n), .idx(idx), .loading(loading), .done(load_done)
   );

   optld_store #(.WW(WW), .NW(NW), .INIT(INIT)) u_store (
      .rd_idx(idx), .rd_word(word)
   );

   for (genvar h = 0; h < HPW; h++) begin : g_pair
      optld_pair_chk #(.BW(BW)) u_chk (
         .half_in (word[h*2*BW +: 2*BW]),
         .byte_out(chk_byte[h]),
         .pair_ok (chk_ok[h])
      );
   end

   for (genvar s = 0; s < NSLOT; s++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            fld_q[s] <= '1;
         else if (loading && idx == AW'(s / HPW))
            fld_q[s] <= chk_byte[s % HPW];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cfg_err <= 1'b0;
      else if (loading && !(&chk_ok))
         cfg_err <= 1'b1;
   end

   assign rdp_level = fld_q[0];
   assign user_cfg  = fld_q[1];
   assign udata0    = fld_q[2];
   assign udata1    = fld_q[3];
   assign prot_mask = {fld_q[7], fld_q[6], fld_q[5], fld_q[4]};
   assign rd_lock   = (rdp_level != UNLOCK);

   // R7
   err_only_in_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cfg_err) |-> !$past(load_done));
   // R7
   err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err |=> cfg_err);
   // R9
   frozen_after_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load_done |=> $stable({prot_mask, rdp_level, user_cfg, udata0, udata1}));
   // R6
   err_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (loading && !chk_ok[0] && idx == '0) |=> (rdp_level == '1 && cfg_err));
endmodule

// File: tb/optld_top_test.sv
`timescale 1ns/1ps
module optld_top_test;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [31:0] prot_mask;
   logic [7:0]  rdp_level, user_cfg, udata0, udata1;
   logic        rd_lock, cfg_err, load_done;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 0;

   logic [7:0] val [8];
   logic [7:0] flip [8];
   logic [31:0] nv [4];

   always #2.5 clk = ~clk;

   optld_top uut (
      .clk(clk), .rst_n(rst_n), .prot_mask(prot_mask), .rdp_level(rdp_level),
      .rd_lock(rd_lock), .user_cfg(user_cfg), .udata0(udata0), .udata1(udata1),
      .cfg_err(cfg_err), .load_done(load_done)
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic build();
      for (int w = 0; w < 4; w++)
         nv[w] = {~val[2*w+1] ^ flip[2*w+1], val[2*w+1], ~val[2*w] ^ flip[2*w], val[2*w]};
   endtask

   function automatic logic [7:0] ex(input int s);
      return (flip[s] != 0) ? 8'hFF : val[s];
   endfunction

   task automatic reload();
      rst_n = 1'b0;
      @(negedge clk);
      for (int w = 0; w < 4; w++) uut.u_store.mem[w] = nv[w];
      @(negedge clk);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
   endtask

   task automatic check_fields(input string tag);
      logic err_exp;
      err_exp = 1'b0;
      for (int s = 0; s < 8; s++) if (flip[s] != 0) err_exp = 1'b1;
      chk(rdp_level == ex(0), {tag, " R3 level"}, rdp_level, ex(0));
      chk(user_cfg == ex(1), {tag, " R3 user"}, user_cfg, ex(1));
      chk(udata0 == ex(2), {tag, " R4 data0"}, udata0, ex(2));
      chk(udata1 == ex(3), {tag, " R4 data1"}, udata1, ex(3));
      chk(prot_mask == {ex(7), ex(6), ex(5), ex(4)}, {tag, " R5 mask"}, prot_mask,
          {ex(7), ex(6), ex(5), ex(4)});
      chk(cfg_err == err_exp, {tag, " R6 err"}, cfg_err, err_exp);
      chk(rd_lock == (ex(0) != 8'hA5), {tag, " R8 lock"}, rd_lock, ex(0) != 8'hA5);
      chk(load_done == 1'b1, {tag, " R2 done"}, load_done, 1);
   endtask

   initial begin
      for (int s = 0; s < 8; s++) begin val[s] = 8'(s * 29 + 3); flip[s] = 0; end
      build();
      // R1: reset state
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      chk(load_done == 0 && cfg_err == 0, "R1 flags", {cfg_err, load_done}, 0);
      chk({prot_mask, rdp_level, user_cfg, udata0, udata1} == '1 && rd_lock,
          "R1 bytes", rdp_level, 8'hFF);
      for (int w = 0; w < 4; w++) uut.u_store.mem[w] = nv[w];
      // R2: one word per edge, done after fourth edge
      rst_n = 1'b1;
      @(negedge clk);
      chk(rdp_level == val[0] && udata0 == 8'hFF, "R2 first word only", {rdp_level, udata0},
          {val[0], 8'hFF});
      repeat (2) @(negedge clk);
      chk(load_done == 0, "R2 not done after 3", load_done, 0);
      @(negedge clk);
      chk(load_done == 1, "R2 done after 4", load_done, 1);
      check_fields("base");

      // R3 R4 R5: several valid patterns
      for (int p = 0; p < 6; p++) begin
         for (int s = 0; s < 8; s++) val[s] = 8'(s * 37 + p * 71 + 5);
         build();
         reload();
         check_fields("pattern");
      end

      // R8: sweep every level code
      for (int s = 0; s < 8; s++) val[s] = 8'(s * 13 + 1);
      for (int c = 0; c < 256; c++) begin
         val[0] = 8'(c);
         build();
         reload();
         chk(rdp_level == 8'(c), "R8 level sweep", rdp_level, c);
         chk(rd_lock == (c != 8'hA5), "R8 lock sweep", rd_lock, c != 8'hA5);
      end

      // R6: each slot, each complement bit corrupted
      for (int s = 0; s < 8; s++) begin
         for (int k = 0; k < 8; k++) begin
            for (int t = 0; t < 8; t++) begin val[t] = 8'(t * 41 + k + 7); flip[t] = 0; end
            val[0] = 8'hA5;
            flip[s] = 8'(1 << k);
            build();
            reload();
            check_fields("corrupt");
         end
      end

      // R7: error holds, then clears on a clean reload
      repeat (20) @(negedge clk);
      chk(cfg_err == 1, "R7 err held", cfg_err, 1);
      for (int t = 0; t < 8; t++) flip[t] = 0;
      build();
      reload();
      chk(cfg_err == 0, "R7 err cleared by reload", cfg_err, 0);

      // R9: changes after load are ignored until reset
      for (int w = 0; w < 4; w++) uut.u_store.mem[w] = ~nv[w];
      repeat (10) @(negedge clk);
      check_fields("R9 frozen");
      for (int t = 0; t < 8; t++) val[t] = 8'(t * 17 + 90);
      build();
      reload();
      check_fields("R9 reload");

      finished = 1;
      $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end
endmodule